// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous true dual-port RAM shared by a left and a right agent on one clock. Each side can read or write any word on any cycle. Writes are masked per byte lane. A read returns the whole word on the cycle after the request is sampled.

The two highest words double as mailboxes. The top word belongs to the right side and the word just below it belongs to the left side. When one side writes into the mailbox owned by the other side, the owner's active-low interrupt drops. The interrupt rises again when the owner reads its own mailbox. An asynchronous active-low master reset releases both interrupts and clears the read registers.

Top module: `mbox_dpram`

## Requirements
- R1: A write (enable high, write strobe `xxWrN` low) updates only the 9-bit lanes whose byte-enable bit is 1. Bit b covers data bits 9b+8..9b. A read (enable high, `xxWrN` high) presents the whole stored word on `xxRdata` after the rising edge that samples it.
- R2: A write by the left side to address 2^ADDR_W-1 drives `rtIrqN` low after that edge. A write by the right side to address 2^ADDR_W-2 drives `lfIrqN` low after that edge.
- R3: A read by the right side of address 2^ADDR_W-1 drives `rtIrqN` high after that edge. A read by the left side of address 2^ADDR_W-2 drives `lfIrqN` high after that edge.
- R4: A mailbox access with all four byte-enable bits at 0 neither sets nor clears any interrupt. A write of this kind also leaves the stored word unchanged.
- R5: Reading the other side's mailbox leaves that side's interrupt unchanged. Writing one's own mailbox does not lower one's own interrupt.
- R6: When a set and a clear of the same interrupt fall on the same edge, the interrupt ends up low (asserted).
- R7: `rstN` low forces `lfIrqN` and `rtIrqN` high and both read registers to zero at once, without waiting for a clock edge.
- R8: With its enable low, a side writes nothing, keeps its `xxRdata`, and causes no interrupt change.
- R9: When one side reads a word on the same edge that the other side writes it, the reader gets the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock, rising edge |
| rstN | input | 1 | Asynchronous master reset, active low |
| lfEn | input | 1 | Left access enable, active high |
| lfWrN | input | 1 | Left direction: 0 write, 1 read |
| lfAddr | input | ADDR_W | Left word address |
| lfWdata | input | DATA_W | Left write data |
| lfBe | input | BE_W | Left byte-lane enables, active high |
| lfRdata | output | DATA_W | Left registered read data |
| lfIrqN | output | 1 | Left mailbox interrupt, active low |
| rtEn | input | 1 | Right access enable, active high |
| rtWrN | input | 1 | Right direction: 0 write, 1 read |
| rtAddr | input | ADDR_W | Right word address |
| rtWdata | input | DATA_W | Right write data |
| rtBe | input | BE_W | Right byte-lane enables, active high |
| rtRdata | output | DATA_W | Right registered read data |
| rtIrqN | output | 1 | Right mailbox interrupt, active low |

## Verification
The assertions assume that the two sides never write the same address on the same edge, because the stored result of such a collision is left open. They also assume that `rstN` is released away from a rising edge. The stimulus drives every input on the falling clock edge, so each sampled value is stable around the rising edge. Every access pattern the bench issues keeps the two sides' write addresses apart whenever both sides write on one edge. Reset is asserted and released between edges only.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Per-edge access strobes from control to the storage datapath
  typedef struct packed {
    logic wrL;
    logic wrR;
    logic rdL;
    logic rdR;
  } memStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lfEn,
  input  logic              lfWrN,
  input  logic [ADDR_W-1:0] lfAddr,
  input  logic [BE_W-1:0]   lfBe,
  input  logic              rtEn,
  input  logic              rtWrN,
  input  logic [ADDR_W-1:0] rtAddr,
  input  logic [BE_W-1:0]   rtBe,
  output memStrobe_t        strb,
  output logic              lfIrqN,
  output logic              rtIrqN
);
  localparam logic [ADDR_W-1:0] MBOX_R = '1;
  localparam logic [ADDR_W-1:0] MBOX_L = MBOX_R - 1'b1;

  logic [1:0]        en, isWr, anyBe, flag;
  logic [ADDR_W-1:0] addr [2];

  assign en     = {rtEn, lfEn};
  assign isWr   = {~rtWrN, ~lfWrN};
  assign anyBe  = {|rtBe, |lfBe};
  assign addr[0] = lfAddr;
  assign addr[1] = rtAddr;

  assign strb.wrL = lfEn & ~lfWrN;
  assign strb.wrR = rtEn & ~rtWrN;
  assign strb.rdL = lfEn &  lfWrN;
  assign strb.rdR = rtEn &  rtWrN;

  // One flag per side: index 0 left, index 1 right
  for (genvar p = 0; p < 2; p++) begin : g_flag
    localparam logic [ADDR_W-1:0] OWN = (p == 1) ? MBOX_R : MBOX_L;
    localparam int OTH = 1 - p;
    logic setF, clrF, flagQ;

    assign setF = en[OTH] & isWr[OTH] & anyBe[OTH] & (addr[OTH] == OWN);
    assign clrF = en[p] & ~isWr[p] & anyBe[p] & (addr[p] == OWN);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      flagQ <= 1'b0;
      else if (setF)  flagQ <= 1'b1;
      else if (clrF)  flagQ <= 1'b0;
    end
    assign flag[p] = flagQ;
  end

  assign lfIrqN = ~flag[0];
  assign rtIrqN = ~flag[1];
endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strb,
  input  logic [ADDR_W-1:0] lfAddr,
  input  logic [DATA_W-1:0] lfWdata,
  input  logic [BE_W-1:0]   lfBe,
  input  logic [ADDR_W-1:0] rtAddr,
  input  logic [DATA_W-1:0] rtWdata,
  input  logic [BE_W-1:0]   rtBe,
  output logic [DATA_W-1:0] lfRdata,
  output logic [DATA_W-1:0] rtRdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / BE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage: lane-masked writes, no reset on the array
  always_ff @(posedge clk) begin
    for (int b = 0; b < BE_W; b++) begin
      if (strb.wrL && lfBe[b])
        mem[lfAddr][b*LANE_W +: LANE_W] <= lfWdata[b*LANE_W +: LANE_W];
      if (strb.wrR && rtBe[b])
        mem[rtAddr][b*LANE_W +: LANE_W] <= rtWdata[b*LANE_W +: LANE_W];
    end
  end

  // Read registers sample the pre-write contents
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfRdata <= '0;
      rtRdata <= '0;
    end else begin
      if (strb.rdL) lfRdata <= mem[lfAddr];
      if (strb.rdR) rtRdata <= mem[rtAddr];
    end
  end
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lfEn,
  input  logic              lfWrN,
  input  logic [ADDR_W-1:0] lfAddr,
  input  logic [DATA_W-1:0] lfWdata,
  input  logic [BE_W-1:0]   lfBe,
  output logic [DATA_W-1:0] lfRdata,
  output logic              lfIrqN,
  input  logic              rtEn,
  input  logic              rtWrN,
  input  logic [ADDR_W-1:0] rtAddr,
  input  logic [DATA_W-1:0] rtWdata,
  input  logic [BE_W-1:0]   rtBe,
  output logic [DATA_W-1:0] rtRdata,
  output logic              rtIrqN
);
  memStrobe_t strb;

  mbox_ctrl #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lfEn(lfEn), .lfWrN(lfWrN), .lfAddr(lfAddr), .lfBe(lfBe),
    .rtEn(rtEn), .rtWrN(rtWrN), .rtAddr(rtAddr), .rtBe(rtBe),
    .strb(strb), .lfIrqN(lfIrqN), .rtIrqN(rtIrqN)
  );

  mbox_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lfAddr(lfAddr), .lfWdata(lfWdata), .lfBe(lfBe),
    .rtAddr(rtAddr), .rtWdata(rtWdata), .rtBe(rtBe),
    .lfRdata(lfRdata), .rtRdata(rtRdata)
  );
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              lfEn,
  input logic              lfWrN,
  input logic [ADDR_W-1:0] lfAddr,
  input logic [BE_W-1:0]   lfBe,
  input logic [DATA_W-1:0] lfRdata,
  input logic              lfIrqN,
  input logic              rtEn,
  input logic              rtWrN,
  input logic [ADDR_W-1:0] rtAddr,
  input logic [BE_W-1:0]   rtBe,
  input logic [DATA_W-1:0] rtRdata,
  input logic              rtIrqN
);
  localparam logic [ADDR_W-1:0] MBOX_R = '1;
  localparam logic [ADDR_W-1:0] MBOX_L = MBOX_R - 1'b1;

  logic setR, clrR, setL, clrL;
  assign setR = lfEn && !lfWrN && lfAddr == MBOX_R && |lfBe;
  assign clrR = rtEn &&  rtWrN && rtAddr == MBOX_R && |rtBe;
  assign setL = rtEn && !rtWrN && rtAddr == MBOX_L && |rtBe;
  assign clrL = lfEn &&  lfWrN && lfAddr == MBOX_L && |lfBe;

  // R2, R6: a set always lands, even against a clear
  p_set_right_r2: assert property (@(posedge clk) disable iff (!rstN)
    setR |=> !rtIrqN);
  p_set_left_r2: assert property (@(posedge clk) disable iff (!rstN)
    setL |=> !lfIrqN);

  // R3
  p_clear_right_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clrR && !setR) |=> rtIrqN);
  p_clear_left_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clrL && !setL) |=> lfIrqN);

  // R4, R5: no qualifying access means no interrupt change
  p_hold_right_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!setR && !clrR) |=> $stable(rtIrqN));
  p_hold_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!setL && !clrL) |=> $stable(lfIrqN));

  // R8: read register holds when its side does not read
  p_rdata_hold_left_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(lfEn && lfWrN) |=> $stable(lfRdata));
  p_rdata_hold_right_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(rtEn && rtWrN) |=> $stable(rtRdata));

  // R7
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_r7: assert (lfIrqN && rtIrqN && lfRdata == '0 && rtRdata == '0);
    end
  end
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .lfEn(lfEn), .lfWrN(lfWrN), .lfAddr(lfAddr), .lfBe(lfBe),
  .lfRdata(lfRdata), .lfIrqN(lfIrqN),
  .rtEn(rtEn), .rtWrN(rtWrN), .rtAddr(rtAddr), .rtBe(rtBe),
  .rtRdata(rtRdata), .rtIrqN(rtIrqN)
);

// File: tb/mbox_dpram_test.sv
`timescale 1ns/1ps
module mbox_dpram_test;
  localparam int MR = 63;
  localparam int ML = 62;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lfEn = 0, lfWrN = 1, rtEn = 0, rtWrN = 1;
  logic [5:0]  lfAddr = '0, rtAddr = '0;
  logic [35:0] lfWdata = '0, rtWdata = '0;
  logic [3:0]  lfBe = '0, rtBe = '0;
  logic [35:0] lfRdata, rtRdata;
  logic        lfIrqN, rtIrqN;

  int tests = 0;
  int fails = 0;

  // reference state
  logic [35:0] refMem [64];
  logic [35:0] eRdL = '0, eRdR = '0;
  bit fL = 0, fR = 0;

  always #4 clk = ~clk;

  mbox_dpram uut (
    .clk(clk), .rstN(rstN),
    .lfEn(lfEn), .lfWrN(lfWrN), .lfAddr(lfAddr), .lfWdata(lfWdata), .lfBe(lfBe),
    .lfRdata(lfRdata), .lfIrqN(lfIrqN),
    .rtEn(rtEn), .rtWrN(rtWrN), .rtAddr(rtAddr), .rtWdata(rtWdata), .rtBe(rtBe),
    .rtRdata(rtRdata), .rtIrqN(rtIrqN)
  );

  task automatic chk(string tag, string what, logic [35:0] act, logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "lfRdata", lfRdata, eRdL);
    chk(tag, "rtRdata", rtRdata, eRdR);
    chk(tag, "lfIrqN", {35'd0, lfIrqN}, {35'd0, !fL});
    chk(tag, "rtIrqN", {35'd0, rtIrqN}, {35'd0, !fR});
  endtask

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] be);
    logic [35:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*9 +: 9] = nw[b*9 +: 9];
    return r;
  endfunction

  // One cycle: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(string tag,
                      bit le, bit lw, int la, logic [35:0] ld, logic [3:0] lb,
                      bit re, bit rw, int ra, logic [35:0] rd, logic [3:0] rb);
    bit sR, cR, sL, cL;
    lfEn = le; lfWrN = !lw; lfAddr = la[5:0]; lfWdata = ld; lfBe = lb;
    rtEn = re; rtWrN = !rw; rtAddr = ra[5:0]; rtWdata = rd; rtBe = rb;
    @(posedge clk);
    if (le && !lw) eRdL = refMem[la];
    if (re && !rw) eRdR = refMem[ra];
    if (le && lw) refMem[la] = merge(refMem[la], ld, lb);
    if (re && rw) refMem[ra] = merge(refMem[ra], rd, rb);
    sR = le && lw && la == MR && lb != 0;
    cR = re && !rw && ra == MR && rb != 0;
    sL = re && rw && ra == ML && rb != 0;
    cL = le && !lw && la == ML && lb != 0;
    if (sR) fR = 1; else if (cR) fR = 0;
    if (sL) fL = 1; else if (cL) fL = 0;
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic lWr(string tag, int a, logic [35:0] d, logic [3:0] be);
    step(tag, 1, 1, a, d, be, 0, 0, 0, '0, '0);
  endtask
  task automatic rWr(string tag, int a, logic [35:0] d, logic [3:0] be);
    step(tag, 0, 0, 0, '0, '0, 1, 1, a, d, be);
  endtask
  task automatic lRd(string tag, int a, logic [3:0] be);
    step(tag, 1, 0, a, '0, be, 0, 0, 0, '0, '0);
  endtask
  task automatic rRd(string tag, int a, logic [3:0] be);
    step(tag, 0, 0, 0, '0, '0, 1, 0, a, '0, be);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) refMem[i] = 'x;
    @(negedge clk);
    checkAll("R7 reset state");
    @(negedge clk);
    rstN = 1'b1;

    // R1: fill from both sides, read back across sides
    for (int i = 0; i < 8; i++) lWr("R1 fill", i, 36'h1_0000_0000 + 36'(i * 37), 4'hF);
    for (int i = 8; i < 16; i++) rWr("R1 fill", i, 36'hA_5A5A_0000 + 36'(i), 4'hF);
    for (int i = 0; i < 16; i++) step("R1 read", 1, 0, i, '0, 4'hF, 1, 0, 15 - i, '0, 4'hF);
    lWr("R1 lanes", 3, 36'hF_FFFF_FFFF, 4'b0101);
    rWr("R1 lanes", 9, 36'h0_0000_0000, 4'b1010);
    step("R1 lane read", 1, 0, 9, '0, 4'h0, 1, 0, 3, '0, 4'h0);

    // R2/R3 right mailbox
    lWr("R2 set right", MR, 36'h1_2345_6789, 4'hF);
    rRd("R3 clear right", MR, 4'b0001);
    // R2/R3 left mailbox
    rWr("R2 set left", ML, 36'h9_8765_4321, 4'b1000);
    lRd("R3 clear left", ML, 4'b0010);

    // R4: zero byte enables
    lWr("R4 no set", MR, 36'h0_DEAD_BEEF, 4'h0);
    rRd("R4 data kept", MR, 4'hF);
    lWr("R2 set again", MR, 36'h0_0000_0011, 4'b0100);
    rRd("R4 no clear", MR, 4'h0);
    rRd("R3 clear", MR, 4'hF);

    // R5: foreign read and own write
    rWr("R2 set left", ML, 36'h5_5555_5555, 4'hF);
    rRd("R5 foreign read", ML, 4'hF);
    rWr("R5 own write", MR, 36'h3_3333_3333, 4'hF);
    lWr("R5 own write", ML, 36'h4_4444_4444, 4'hF);
    lRd("R5 check", ML, 4'hF);
    lRd("R3 clear left", ML, 4'hF);

    // R6 + R9: set and clear same edge, reader sees old word
    step("R6 R9 set wins", 1, 1, MR, 36'h7_7777_7777, 4'hF, 1, 0, MR, '0, 4'hF);
    rRd("R9 new word", MR, 4'hF);
    step("R6 left set wins", 1, 0, ML, '0, 4'hF, 1, 1, ML, 36'h6_0606_0606, 4'hF);
    lRd("R3 clear left", ML, 4'hF);
    step("R9 cross", 1, 1, 5, 36'hC_CCCC_CCCC, 4'hF, 1, 0, 5, '0, 4'hF);
    step("R9 cross rev", 1, 0, 10, '0, 4'hF, 1, 1, 10, 36'hB_BBBB_BBBB, 4'hF);
    step("R9 after", 1, 0, 5, '0, 4'hF, 1, 0, 10, '0, 4'hF);

    // R8: disabled sides
    step("R8 no write", 0, 1, 0, 36'h0_BAD0_BAD0, 4'hF, 0, 1, MR, 36'h0_BAD1_BAD1, 4'hF);
    step("R8 no read", 0, 0, 1, '0, 4'hF, 0, 0, ML, '0, 4'hF);
    step("R8 verify", 1, 0, 0, '0, 4'hF, 1, 0, MR, '0, 4'hF);
    lWr("R8 prep set", MR, 36'h0_0000_0001, 4'hF);
    step("R8 no clear", 0, 0, 0, '0, 4'h0, 0, 0, MR, '0, 4'hF);

    // R7: asynchronous reset mid-cycle with a flag set
    rWr("R7 prep set", ML, 36'h0_0000_0002, 4'hF);
    #2 rstN = 1'b0;
    #1;
    fL = 0; fR = 0; eRdL = '0; eRdR = '0;
    checkAll("R7 async reset");
    @(negedge clk);
    checkAll("R7 held");
    rstN = 1'b1;
    lRd("R1 after reset", 2, 4'hF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule